// File: doc/BRIEF.md
# Instruction Cache Way Parity Checker

This block checks the stored protection bits of one instruction-cache way. The way's raw tag words are presented first. Up to four data beats may follow, each holding two instructions and a 17-bit side word. The block recomputes every even-parity bit from the covered bits and compares it with the stored bit. Mismatches are collected into a 32-bit result mask with two flags: one for tag parity and one for data parity. A done strobe closes the way, and one cycle later the block presents the mask with a valid pulse.

A tag is accepted on `tag_valid`. Accepting a tag clears the previous way's result and also latches `check_data`, which sets whether the following beats are examined. A diagnostic routine walks through the ways of a set, one way at a time. It feeds each way's words to this block and reads back the mask, which shows which class of error the stored bits really contain.

Top module: `icpar_top`

## Requirements
- R1: After reset, `result_mask` is zero and `result_valid` is low. Beats arriving before any tag has been accepted are ignored.
- R2: The valid flag is tag-high bit 29 and its parity copy is tag-high bit 27. When these two bits differ, the tag flag (result bit 29) is set, whether the entry is valid or not.
- R3: When the entry is valid, tag-low bit 10 must equal the XOR of tag-low bits 23..0, leaving out bits 10 and 11. A mismatch sets result bit 29. When the entry is invalid, this check has no effect.
- R4: When the entry is valid, tag-low bit 11 must equal the XOR of tag-low bits 63..24. A mismatch sets result bit 29. When the entry is invalid, this check has no effect.
- R5: In each beat, side-word bit 16 must equal the XOR of side bits 15..8, which hold the predecode byte. A mismatch sets the data flag (result bit 28).
- R6: Side bits 7..4 hold the byte parities of instruction A, and bits 3..0 those of instruction B. Within each nibble, bit j holds the XOR of instruction byte j, so the most significant byte maps to the most significant nibble bit. Any mismatch sets result bit 28.
- R7: Beats are examined only when `check_data` was high at the last accepted tag. Otherwise beats leave result bit 28 at zero.
- R8: Result bit 28 is the OR over all examined beats of one way. Accepting a new tag replaces bit 29 with the new tag's result and clears bit 28.
- R9: At most four beats are examined per way. Any beat after the fourth has no effect.
- R10: `result_valid` goes high exactly one cycle after `done`, for one cycle. At that point `result_mask` includes any beat or tag given in the `done` cycle. All mask bits other than 29 and 28 are always zero.
- R11: When `tag_valid` and `beat_valid` are high in the same cycle, the tag is accepted and the beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_valid | input | 1 | Accepts a new way's tag words |
| tag_hi | input | 32 | Raw tag-high word |
| tag_lo | input | 64 | Raw tag-low word |
| check_data | input | 1 | Examine the following beats; latched with the tag |
| beat_valid | input | 1 | Qualifies one data beat |
| beat_insn_a | input | 32 | Instruction A of the beat |
| beat_insn_b | input | 32 | Instruction B of the beat |
| beat_side | input | 17 | Predecode byte, its parity, and the instruction byte parities |
| done | input | 1 | Ends the checks for the current way |
| result_mask | output | 32 | Bit 29 tag parity, bit 28 data parity |
| result_valid | output | 1 | Result pulse, one cycle after done |

## Verification
The bench targets the following corner cases:
- An invalid entry with broken tag-low parity. A design that ignores the valid gate would report a tag error here.
- An invalid entry whose valid copy mismatches. A design that gates this check on the valid flag would miss it.
- Bad beats arriving while `check_data` is low, or as a fifth beat. A design that lets them through would set a spurious data flag.
- A beat given together with a new tag, and a clean way following a bad one. These show whether the tag takes priority and whether the mask is cleared.

Each instruction byte is corrupted in turn to catch a reversed nibble mapping. Random ways with fixed-seed bit flips cover the rest.

// File: rtl/icpar_pkg.sv
package icpar_pkg;
  parameter int TAG_HI_W     = 32;
  parameter int TAG_LO_W     = 64;
  parameter int INSN_W       = 32;
  parameter int BYTE_W       = 8;
  parameter int SIDE_W       = 17;
  parameter int BEATS        = 4;
  parameter int RES_W        = 32;

  parameter int VLD_BIT      = 29;
  parameter int VLD_COPY_BIT = 27;
  parameter int LO_PAR0_BIT  = 10;
  parameter int LO_PAR1_BIT  = 11;
  parameter int LO_SPLIT     = 24;

  parameter int PD_LSB       = 8;
  parameter int PD_PAR_BIT   = 16;
  parameter int NIB_A_LSB    = 4;
  parameter int NIB_B_LSB    = 0;

  parameter int TAG_FLAG_BIT  = 29;
  parameter int DATA_FLAG_BIT = 28;

  localparam int BYTES_PER_INSN = INSN_W / BYTE_W;
  localparam int CNT_W          = $clog2(BEATS + 1);

  typedef struct packed {
    logic tag_flag;
    logic data_flag;
  } icpar_flags_t;
endpackage

// File: rtl/icpar_tag_chk.sv
module icpar_tag_chk
  import icpar_pkg::*;
(
  input  logic [TAG_HI_W-1:0] tag_hi,
  input  logic [TAG_LO_W-1:0] tag_lo,
  output logic                tag_err
);
  localparam int LOW_W  = LO_SPLIT;
  localparam int HIGH_W = TAG_LO_W - LO_SPLIT;

  function automatic logic [LOW_W-1:0] low_cover();
    logic [LOW_W-1:0] m;
    m = '1;
    m[LO_PAR0_BIT] = 1'b0;
    m[LO_PAR1_BIT] = 1'b0;
    return m;
  endfunction

  localparam logic [LOW_W-1:0] LOW_MASK = low_cover();

  logic              entry_valid;
  logic              valid_copy_bad;
  logic              low_bad;
  logic              high_bad;
  logic [LOW_W-1:0]  low_bits;
  logic [HIGH_W-1:0] high_bits;
  logic              tag_hi_unused;

  assign entry_valid    = tag_hi[VLD_BIT];
  assign valid_copy_bad = tag_hi[VLD_BIT] ^ tag_hi[VLD_COPY_BIT];
  assign low_bits       = tag_lo[LOW_W-1:0] & LOW_MASK;
  assign high_bits      = tag_lo[TAG_LO_W-1:LO_SPLIT];

  always_comb begin
    low_bad  = tag_lo[LO_PAR0_BIT] ^ (^low_bits);
    high_bad = tag_lo[LO_PAR1_BIT] ^ (^high_bits);
  end

  assign tag_err       = valid_copy_bad | (entry_valid & (low_bad | high_bad));
  assign tag_hi_unused = ^tag_hi;
endmodule

// File: rtl/icpar_beat_chk.sv
module icpar_beat_chk
  import icpar_pkg::*;
(
  input  logic [INSN_W-1:0] insn_a,
  input  logic [INSN_W-1:0] insn_b,
  input  logic [SIDE_W-1:0] side,
  output logic              beat_err
);
  logic [BYTES_PER_INSN-1:0] calc_a;
  logic [BYTES_PER_INSN-1:0] calc_b;
  logic                      pd_bad;
  logic                      nib_bad;

  for (genvar j = 0; j < BYTES_PER_INSN; j++) begin : g_byte
    assign calc_a[j] = ^insn_a[j*BYTE_W +: BYTE_W];
    assign calc_b[j] = ^insn_b[j*BYTE_W +: BYTE_W];
  end

  always_comb begin
    pd_bad  = side[PD_PAR_BIT] ^ (^side[PD_LSB +: BYTE_W]);
    nib_bad = (calc_a != side[NIB_A_LSB +: BYTES_PER_INSN]) ||
              (calc_b != side[NIB_B_LSB +: BYTES_PER_INSN]);
  end

  assign beat_err = pd_bad | nib_bad;
endmodule

// File: rtl/icpar_accum.sv
module icpar_accum
  import icpar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_valid,
  input  logic             tag_err,
  input  logic             check_data,
  input  logic             beat_valid,
  input  logic             beat_err,
  input  logic             done,
  output icpar_flags_t     flags,
  output logic             result_valid
);
  icpar_flags_t   flags_q, flags_d;
  logic           data_en_q, data_en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic           rv_q, rv_d;
  logic           beat_take;

  assign beat_take = !tag_valid && beat_valid && data_en_q &&
                     (cnt_q < CNT_W'(BEATS));

  always_comb begin
    flags_d   = flags_q;
    data_en_d = data_en_q;
    cnt_d     = cnt_q;
    rv_d      = done;
    if (tag_valid) begin
      flags_d.tag_flag  = tag_err;
      flags_d.data_flag = 1'b0;
      data_en_d         = check_data;
      cnt_d             = '0;
    end else if (beat_take) begin
      flags_d.data_flag = flags_q.data_flag | beat_err;
      cnt_d             = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      data_en_q <= 1'b0;
      cnt_q     <= '0;
      rv_q      <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      data_en_q <= data_en_d;
      cnt_q     <= cnt_d;
      rv_q      <= rv_d;
    end
  end

  assign flags        = flags_q;
  assign result_valid = rv_q;

  // R9
  beat_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BEATS));

  // R8
  data_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_valid && flags_q.data_flag) |=> flags_q.data_flag);

  // R7
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_valid && !data_en_q) |=> $stable(flags_q.data_flag));

  // R8
  tag_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_valid |=> $stable(flags_q.tag_flag));

  // R10
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> result_valid);

  // R10
  result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !result_valid);
endmodule

// File: rtl/icpar_top.sv
module icpar_top
  import icpar_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tag_valid,
  input  logic [TAG_HI_W-1:0] tag_hi,
  input  logic [TAG_LO_W-1:0] tag_lo,
  input  logic                check_data,
  input  logic                beat_valid,
  input  logic [INSN_W-1:0]   beat_insn_a,
  input  logic [INSN_W-1:0]   beat_insn_b,
  input  logic [SIDE_W-1:0]   beat_side,
  input  logic                done,
  output logic [RES_W-1:0]    result_mask,
  output logic                result_valid
);
  logic         tag_err;
  logic         beat_err;
  icpar_flags_t flags;

  icpar_tag_chk u_tag (
    .tag_hi  (tag_hi),
    .tag_lo  (tag_lo),
    .tag_err (tag_err)
  );

  icpar_beat_chk u_beat (
    .insn_a   (beat_insn_a),
    .insn_b   (beat_insn_b),
    .side     (beat_side),
    .beat_err (beat_err)
  );

  icpar_accum u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .tag_valid    (tag_valid),
    .tag_err      (tag_err),
    .check_data   (check_data),
    .beat_valid   (beat_valid),
    .beat_err     (beat_err),
    .done         (done),
    .flags        (flags),
    .result_valid (result_valid)
  );

  always_comb begin
    result_mask                = '0;
    result_mask[TAG_FLAG_BIT]  = flags.tag_flag;
    result_mask[DATA_FLAG_BIT] = flags.data_flag;
  end

  // R10
  mask_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_mask & ~((32'd1 << TAG_FLAG_BIT) | (32'd1 << DATA_FLAG_BIT))) == '0);
endmodule

// File: tb/tb_icpar_top.sv
module tb_icpar_top;
  logic        clk;
  logic        rst_n;
  logic        tag_valid;
  logic [31:0] tag_hi;
  logic [63:0] tag_lo;
  logic        check_data;
  logic        beat_valid;
  logic [31:0] beat_insn_a;
  logic [31:0] beat_insn_b;
  logic [16:0] beat_side;
  logic        done;
  logic [31:0] result_mask;
  logic        result_valid;

  int checks;
  int fails;

  icpar_top dut (
    .clk(clk), .rst_n(rst_n), .tag_valid(tag_valid), .tag_hi(tag_hi),
    .tag_lo(tag_lo), .check_data(check_data), .beat_valid(beat_valid),
    .beat_insn_a(beat_insn_a), .beat_insn_b(beat_insn_b),
    .beat_side(beat_side), .done(done), .result_mask(result_mask),
    .result_valid(result_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] qa [8];
  logic [31:0] qb [8];
  logic [16:0] qs [8];

  function automatic logic [3:0] nib(input logic [31:0] w);
    return {^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
  endfunction

  function automatic logic exp_tag(input logic [31:0] hi, input logic [63:0] lo);
    logic e;
    e = hi[29] ^ hi[27];
    if (hi[29]) begin
      if ((^(lo[23:0] & 24'hFFF3FF)) != lo[10]) e = 1'b1;
      if ((^lo[63:24]) != lo[11]) e = 1'b1;
    end
    return e;
  endfunction

  function automatic logic exp_beat(input logic [31:0] a, input logic [31:0] b,
                                    input logic [16:0] s);
    return ((^s[15:8]) != s[16]) || (nib(a) != s[7:4]) || (nib(b) != s[3:0]);
  endfunction

  function automatic logic [16:0] good_side(input logic [31:0] a, input logic [31:0] b,
                                           input logic [7:0] pd);
    return {^pd, pd, nib(a), nib(b)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    tag_valid = 0; beat_valid = 0; done = 0; check_data = 0;
    tag_hi = '0; tag_lo = '0; beat_insn_a = '0; beat_insn_b = '0; beat_side = '0;
  endtask

  task automatic make_tag(output logic [31:0] hi, output logic [63:0] lo, input logic flip);
    hi = $urandom; lo = {$urandom, $urandom};
    hi[27] = hi[29];
    lo[10] = ^(lo[23:0] & 24'hFFF3FF);
    lo[11] = ^lo[63:24];
    if (flip) begin
      if ($urandom_range(0, 1) == 0) hi[$urandom_range(0, 31)] ^= 1'b1;
      else lo[$urandom_range(0, 63)] ^= 1'b1;
    end
  endtask

  task automatic make_beat(input int i, input logic flip);
    qa[i] = $urandom; qb[i] = $urandom;
    qs[i] = good_side(qa[i], qb[i], 8'($urandom));
    if (flip) begin
      case ($urandom_range(0, 2))
        0: qa[i][$urandom_range(0, 31)] ^= 1'b1;
        1: qb[i][$urandom_range(0, 31)] ^= 1'b1;
        default: qs[i][$urandom_range(0, 16)] ^= 1'b1;
      endcase
    end
  endtask

  // Drives one way at negedges: tag, n beats, done; then checks the result.
  task automatic run_way(input string req, input logic [31:0] hi, input logic [63:0] lo,
                         input logic cd, input int n);
    logic [31:0] exp;
    logic dflag;
    dflag = 1'b0;
    for (int i = 0; i < n; i++)
      if (cd && i < 4 && exp_beat(qa[i], qb[i], qs[i])) dflag = 1'b1;
    exp = '0;
    exp[29] = exp_tag(hi, lo);
    exp[28] = dflag;
    @(negedge clk);
    tag_valid = 1; tag_hi = hi; tag_lo = lo; check_data = cd;
    @(negedge clk);
    tag_valid = 0; check_data = 0;
    for (int i = 0; i < n; i++) begin
      beat_valid = 1; beat_insn_a = qa[i]; beat_insn_b = qb[i]; beat_side = qs[i];
      @(negedge clk);
    end
    beat_valid = 0;
    done = 1;
    @(negedge clk);
    done = 0;
    check({req, " valid"}, {31'd0, result_valid}, 32'd1);
    check(req, result_mask, exp);
    @(negedge clk);
    check({req, " pulse"}, {31'd0, result_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] hi;
    logic [63:0] lo;
    void'($urandom(32'd1234));
    checks = 0; fails = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset mask", result_mask, 32'd0);
    check("R1 reset valid", {31'd0, result_valid}, 32'd0);
    rst_n = 1;
    // R1 beat before any tag ignored
    make_beat(0, 1'b0); qs[0][16] ^= 1'b1;
    @(negedge clk);
    beat_valid = 1; beat_insn_a = qa[0]; beat_insn_b = qb[0]; beat_side = qs[0];
    @(negedge clk); beat_valid = 0; done = 1;
    @(negedge clk); done = 0;
    check("R1 early beat", result_mask, 32'd0);

    // R2 invalid entry, copy mismatch
    make_tag(hi, lo, 1'b0); hi[29] = 0; hi[27] = 1;
    run_way("R2 copy mismatch invalid", hi, lo, 1'b0, 0);
    // R3 invalid entry with bad low parity: no effect
    make_tag(hi, lo, 1'b0); hi[29] = 0; hi[27] = 0; lo[10] ^= 1'b1; lo[3] ^= 1'b1; lo[40] ^= 1'b1;
    run_way("R3 R4 invalid ignored", hi, lo, 1'b0, 0);
    // R3 valid, bad low parity
    make_tag(hi, lo, 1'b0); hi[29] = 1; hi[27] = 1; lo[5] ^= 1'b1;
    run_way("R3 low parity", hi, lo, 1'b0, 0);
    // R3 bit 11 is excluded from low cover
    make_tag(hi, lo, 1'b0); hi[29] = 1; hi[27] = 1;
    lo[11] ^= 1'b1; lo[30] ^= 1'b1;
    run_way("R3 exclusion", hi, lo, 1'b0, 0);
    // R4 valid, bad high parity
    make_tag(hi, lo, 1'b0); hi[29] = 1; hi[27] = 1; lo[63] ^= 1'b1;
    run_way("R4 high parity", hi, lo, 1'b0, 0);

    // R6 every instruction byte corrupted in turn
    for (int k = 0; k < 8; k++) begin
      make_tag(hi, lo, 1'b0);
      for (int i = 0; i < 4; i++) make_beat(i, 1'b0);
      if (k < 4) qa[2][k*8] ^= 1'b1; else qb[1][(k-4)*8+7] ^= 1'b1;
      run_way("R6 byte nibble", hi, lo, 1'b1, 4);
    end
    // R6 side nibble bit corrupted
    make_tag(hi, lo, 1'b0);
    for (int i = 0; i < 4; i++) make_beat(i, 1'b0);
    qs[3][7] ^= 1'b1;
    run_way("R6 side bit", hi, lo, 1'b1, 4);
    // R5 predecode parity
    make_tag(hi, lo, 1'b0);
    for (int i = 0; i < 4; i++) make_beat(i, 1'b0);
    qs[0][12] ^= 1'b1;
    run_way("R5 predecode", hi, lo, 1'b1, 4);
    // R7 data not checked
    make_tag(hi, lo, 1'b0);
    for (int i = 0; i < 4; i++) begin make_beat(i, 1'b0); qs[i][16] ^= 1'b1; end
    run_way("R7 data off", hi, lo, 1'b0, 4);
    // R9 fifth bad beat ignored
    make_tag(hi, lo, 1'b0);
    for (int i = 0; i < 6; i++) make_beat(i, i >= 4);
    qs[4][0] ^= 1'b1; qs[5][16] ^= 1'b1;
    run_way("R9 extra beats", hi, lo, 1'b1, 6);
    // R8 bad way followed by clean way clears
    make_tag(hi, lo, 1'b0); hi[29] = 1; hi[27] = 0;
    for (int i = 0; i < 4; i++) begin make_beat(i, 1'b0); qs[i][1] ^= 1'b1; end
    run_way("R8 bad way", hi, lo, 1'b1, 4);
    make_tag(hi, lo, 1'b0);
    for (int i = 0; i < 4; i++) make_beat(i, 1'b0);
    run_way("R8 cleared", hi, lo, 1'b1, 4);

    // R11 beat with tag dropped
    make_tag(hi, lo, 1'b0);
    make_beat(0, 1'b0); qs[0][16] ^= 1'b1;
    @(negedge clk);
    tag_valid = 1; tag_hi = hi; tag_lo = lo; check_data = 1;
    beat_valid = 1; beat_insn_a = qa[0]; beat_insn_b = qb[0]; beat_side = qs[0];
    @(negedge clk);
    tag_valid = 0; beat_valid = 0; check_data = 0; done = 1;
    @(negedge clk); done = 0;
    check("R11 tag priority", result_mask, 32'd0);
    // R10 beat in done cycle included
    make_tag(hi, lo, 1'b0);
    make_beat(0, 1'b0); qs[0][9] ^= 1'b1;
    @(negedge clk);
    tag_valid = 1; tag_hi = hi; tag_lo = lo; check_data = 1;
    @(negedge clk);
    tag_valid = 0; check_data = 0;
    beat_valid = 1; beat_insn_a = qa[0]; beat_insn_b = qb[0]; beat_side = qs[0]; done = 1;
    @(negedge clk); beat_valid = 0; done = 0;
    check("R10 done-cycle beat", result_mask, 32'h1000_0000);
    check("R10 done-cycle valid", {31'd0, result_valid}, 32'd1);

    // R2 R3 R4 R5 R6 R8 random ways
    for (int w = 0; w < 300; w++) begin
      int n;
      logic cd;
      make_tag(hi, lo, $urandom_range(0, 2) == 0);
      n = $urandom_range(0, 5);
      cd = $urandom_range(0, 3) != 0;
      for (int i = 0; i < n; i++) make_beat(i, $urandom_range(0, 5) == 0);
      run_way("R8 random way", hi, lo, cd, n);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule